// File: doc/BRIEF.md
# NAND Flash Bus Command Sequencer

This block is the host side of an 8-bit multiplexed NAND flash link. A client hands it one request at a time: page read, page program, block erase, device reset or status read. Each request carries a row (page) address, a starting column and a byte count. The sequencer then walks the flash bus through the full operation. It holds chip enable low and places commands, address bytes and write data on one shared byte bus. The command-latch and address-latch qualifiers mark what each byte is. Each byte is strobed with a write-enable pulse.

Wherever the device goes busy, the sequencer waits on the ready/busy line. It then reads data back with read-enable pulses, or it reads the status byte and reports the pass/fail bit. Write data enters over a valid/ready stream. Read data leaves over a valid/ready stream that the consumer may stall.

Every strobe width and setup interval is a clock-count parameter. The ready/busy input can be passed through an optional synchronizer.

Top module: `nand_cmd_seq`

## Requirements
- R1: Every outbound byte is transferred by one write-enable low pulse while chip enable is low. The bus byte and both latch qualifiers are stable from the start of the setup interval until write-enable rises.
- R2: The command-latch qualifier is high only for command bytes and the address-latch qualifier only for address bytes. They are never high together. Both are low for data bytes.
- R3: A page read issues a pointer command, then four address bytes, in this order: column[7:0], row[7:0], row[15:8], {7'b0,row[16]}. The pointer command is 00h for column 0–255, 01h for 256–511 and 50h for 512–527.
- R4: A page program issues the pointer command (same coding as R3), then 80h, then the four address bytes of R3. It then sends exactly `req_len` data bytes taken from the write stream in order, and then 10h.
- R5: A block erase issues 60h, then the three row bytes row[7:0], row[15:8], {7'b0,row[16]}, with no column byte, and then D0h.
- R6: After a program or erase confirm, the sequencer waits for ready, issues 70h and reads one byte. `status_fail` then equals bit 0 of that byte.
- R7: Write-enable stays low for exactly T_WL clocks and read-enable for exactly T_RL clocks. Each pulse is preceded by T_SETUP clocks of settled bus and qualifiers and followed by at least T_WH (write) or T_RH (read) clocks high.
- R8: After the read address, and once ready, `req_len` bytes are read with read-enable pulses. The bus is not driven while read-enable is low. Each byte is sampled in the last clock before read-enable rises. Bytes appear on the read stream in order, and each is held until accepted.
- R9: A reset request issues only FFh, then waits for ready before finishing.
- R10: A status request issues 70h, reads one byte and sets `status_fail` from its bit 0.
- R11: `req_ready` is high only when no operation is in progress, and chip enable is then high. `done` is a one-clock pulse at the end of every operation.
- R12: No strobe falls while the device reports busy. After a confirm or read address, the sequencer waits T_WB clocks and then until ready/busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 reset, 4 status |
| req_row | input | ROW_W | Page (row) address |
| req_col | input | COL_W | Starting column 0–527 |
| req_len | input | LEN_W | Data bytes to read or program |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Program data accepted |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Read data accepted |
| done | output | 1 | One-clock end-of-operation pulse |
| status_fail | output | 1 | Bit 0 of last status byte |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command-latch qualifier |
| nf_ale | output | 1 | Address-latch qualifier |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Bus byte driven to flash |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Bus byte from flash |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
Reads are issued with starting columns in each of the three column regions. This separates the 00h, 01h and 50h pointer codings, and the column byte shows whether the upper column bits were dropped correctly. Programs and erases run with status bytes whose bit 0 is set and clear, so an inverted or missing status capture is exposed. The erase address stream shows whether the column cycle is skipped. Stalls on the write stream and heavy backpressure on the read stream show whether bytes are lost, duplicated or reordered. A device stub that stays busy well past T_WB catches any sequencer that ignores ready/busy.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_PROG   = 3'd1,
      OP_ERASE  = 3'd2,
      OP_RESET  = 3'd3,
      OP_STATUS = 3'd4
   } nsq_op_e;

   typedef enum logic [1:0] {
      BK_CMD  = 2'd0,
      BK_ADDR = 2'd1,
      BK_WDAT = 2'd2,
      BK_RDAT = 2'd3
   } nsq_kind_e;

   localparam logic [7:0] CMD_AREA_LO   = 8'h00;
   localparam logic [7:0] CMD_AREA_HI   = 8'h01;
   localparam logic [7:0] CMD_AREA_SPR  = 8'h50;
   localparam logic [7:0] CMD_PROG_GO   = 8'h80;
   localparam logic [7:0] CMD_PROG_CONF = 8'h10;
   localparam logic [7:0] CMD_ERASE_GO  = 8'h60;
   localparam logic [7:0] CMD_ERASE_CFM = 8'hD0;
   localparam logic [7:0] CMD_STATUS    = 8'h70;
   localparam logic [7:0] CMD_RESET     = 8'hFF;

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

   // Pointer command replaces column bits 9:8
   function automatic logic [7:0] ptr_cmd(logic [1:0] col_hi);
      if (col_hi[1])      return CMD_AREA_SPR;
      else if (col_hi[0]) return CMD_AREA_HI;
      else                return CMD_AREA_LO;
   endfunction

   // Address cycle idx: 0 column, 1..3 row bytes low to high
   function automatic logic [7:0] addr_byte(logic [1:0] idx, logic [23:0] row,
                                            logic [7:0] col_lo);
      case (idx)
         2'd0:    return col_lo;
         2'd1:    return row[7:0];
         2'd2:    return row[15:8];
         default: return row[23:16];
      endcase
   endfunction

endpackage

// File: rtl/nsq_strobe.sv
module nsq_strobe
   import nsq_pkg::*;
#(
   parameter int T_SETUP = 2,
   parameter int T_WL    = 3,
   parameter int T_WH    = 2,
   parameter int T_RL    = 3,
   parameter int T_RH    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  nsq_kind_e  kind,
   input  logic [7:0] byte_in,
   input  logic [7:0] io_in,
   output logic       cle,
   output logic       ale,
   output logic       we_n,
   output logic       re_n,
   output logic [7:0] io_out,
   output logic       io_oe,
   output logic [7:0] rd_byte,
   output logic       done
);
   localparam int TMAX = max2(max2(max2(T_SETUP, T_WL), max2(T_WH, T_RL)), T_RH);
   localparam int CW   = $clog2(TMAX + 1);

   typedef enum logic [1:0] {G_IDLE, G_SETUP, G_LOW, G_HIGH} stage_e;

   stage_e          stage;
   logic [CW-1:0]   cnt;
   logic            is_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage   <= G_IDLE;
         cnt     <= '0;
         is_rd   <= 1'b0;
         cle     <= 1'b0;
         ale     <= 1'b0;
         we_n    <= 1'b1;
         re_n    <= 1'b1;
         io_out  <= '0;
         io_oe   <= 1'b0;
         rd_byte <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (stage)
            G_IDLE: if (start) begin
               stage  <= G_SETUP;
               cnt    <= CW'(T_SETUP - 1);
               is_rd  <= (kind == BK_RDAT);
               cle    <= (kind == BK_CMD);
               ale    <= (kind == BK_ADDR);
               io_oe  <= (kind != BK_RDAT);
               io_out <= (kind == BK_RDAT) ? 8'h00 : byte_in;
            end
            G_SETUP: if (cnt == '0) begin
               stage <= G_LOW;
               cnt   <= is_rd ? CW'(T_RL - 1) : CW'(T_WL - 1);
               if (is_rd) re_n <= 1'b0;
               else       we_n <= 1'b0;
            end else cnt <= cnt - CW'(1);
            G_LOW: if (cnt == '0) begin
               stage <= G_HIGH;
               cnt   <= is_rd ? CW'(T_RH - 1) : CW'(T_WH - 1);
               we_n  <= 1'b1;
               re_n  <= 1'b1;
               if (is_rd) rd_byte <= io_in;
            end else cnt <= cnt - CW'(1);
            default: if (cnt == '0) begin
               stage <= G_IDLE;
               done  <= 1'b1;
               cle   <= 1'b0;
               ale   <= 1'b0;
               io_oe <= 1'b0;
            end else cnt <= cnt - CW'(1);
         endcase
      end
   end

   a_r2_qual_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   a_r1_bus_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> $stable({cle, ale, io_out, io_oe}));
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));

endmodule

// File: rtl/nsq_ctrl.sv
module nsq_ctrl
   import nsq_pkg::*;
#(
   parameter int ROW_W = 17,
   parameter int COL_W = 10,
   parameter int LEN_W = 10,
   parameter int T_WB  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_op,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic             done,
   output logic             status_fail,
   output logic             ce_n,
   input  logic             rb_s,
   output logic             stb_start,
   output nsq_kind_e        stb_kind,
   output logic [7:0]       stb_byte,
   input  logic             stb_done,
   input  logic [7:0]       stb_rd
);
   localparam int WBW = $clog2(T_WB + 1);

   typedef enum logic [3:0] {
      S_IDLE, S_CMD_A, S_CMD_B, S_ADDR, S_WDATA, S_CONF,
      S_WAIT, S_RDATA, S_STAT_CMD, S_STAT_RD, S_DONE
   } st_e;

   st_e              state;
   nsq_op_e          op_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [LEN_W-1:0] len_q, cnt;
   logic [1:0]       aidx;
   logic [WBW-1:0]   wb_cnt;
   logic             pend;

   assign req_ready = (state == S_IDLE);
   assign ce_n      = (state == S_IDLE);

   always_comb begin
      stb_start = 1'b0;
      stb_kind  = BK_CMD;
      stb_byte  = 8'h00;
      wr_ready  = 1'b0;
      case (state)
         S_CMD_A: begin
            stb_start = !pend;
            case (op_q)
               OP_READ, OP_PROG: stb_byte = ptr_cmd(col_q[9:8]);
               OP_ERASE:         stb_byte = CMD_ERASE_GO;
               OP_RESET:         stb_byte = CMD_RESET;
               default:          stb_byte = CMD_STATUS;
            endcase
         end
         S_CMD_B:    begin stb_start = !pend; stb_byte = CMD_PROG_GO; end
         S_ADDR: begin
            stb_start = !pend;
            stb_kind  = BK_ADDR;
            stb_byte  = addr_byte(aidx, 24'(row_q), col_q[7:0]);
         end
         S_WDATA: begin
            wr_ready  = !pend && (cnt < len_q);
            stb_start = wr_ready && wr_valid;
            stb_kind  = BK_WDAT;
            stb_byte  = wr_data;
         end
         S_CONF: begin
            stb_start = !pend;
            stb_byte  = (op_q == OP_PROG) ? CMD_PROG_CONF : CMD_ERASE_CFM;
         end
         S_RDATA: begin
            stb_start = !pend && !rd_valid && (cnt < len_q);
            stb_kind  = BK_RDAT;
         end
         S_STAT_CMD: begin stb_start = !pend; stb_byte = CMD_STATUS; end
         S_STAT_RD:  begin stb_start = !pend; stb_kind = BK_RDAT; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;  op_q <= OP_READ;  row_q <= '0;  col_q <= '0;
         len_q <= '0;  cnt <= '0;  aidx <= '0;  wb_cnt <= '0;  pend <= 1'b0;
         rd_valid <= 1'b0;  rd_data <= '0;  done <= 1'b0;  status_fail <= 1'b0;
      end else begin
         done <= 1'b0;
         if (stb_start)     pend <= 1'b1;
         else if (stb_done) pend <= 1'b0;
         if (rd_valid && rd_ready) rd_valid <= 1'b0;
         case (state)
            S_IDLE: if (req_valid) begin
               op_q  <= nsq_op_e'(req_op);
               row_q <= req_row;  col_q <= req_col;  len_q <= req_len;
               cnt   <= '0;
               aidx  <= (nsq_op_e'(req_op) == OP_ERASE) ? 2'd1 : 2'd0;
               state <= S_CMD_A;
            end
            S_CMD_A: if (stb_done) begin
               wb_cnt <= '0;
               case (op_q)
                  OP_READ, OP_ERASE: state <= S_ADDR;
                  OP_PROG:           state <= S_CMD_B;
                  OP_RESET:          state <= S_WAIT;
                  default:           state <= S_STAT_RD;
               endcase
            end
            S_CMD_B: if (stb_done) state <= S_ADDR;
            S_ADDR: if (stb_done) begin
               wb_cnt <= '0;
               if (aidx == 2'd3) begin
                  case (op_q)
                     OP_READ: state <= S_WAIT;
                     OP_PROG: state <= S_WDATA;
                     default: state <= S_CONF;
                  endcase
               end else aidx <= aidx + 2'd1;
            end
            S_WDATA: begin
               if (stb_done) cnt <= cnt + LEN_W'(1);
               else if (!pend && cnt == len_q) state <= S_CONF;
            end
            S_CONF: if (stb_done) begin wb_cnt <= '0; state <= S_WAIT; end
            S_WAIT: begin
               if (wb_cnt != WBW'(T_WB)) wb_cnt <= wb_cnt + WBW'(1);
               else if (rb_s) begin
                  cnt <= '0;
                  case (op_q)
                     OP_READ:  state <= S_RDATA;
                     OP_RESET: state <= S_DONE;
                     default:  state <= S_STAT_CMD;
                  endcase
               end
            end
            S_RDATA: begin
               if (stb_done) begin
                  rd_valid <= 1'b1;
                  rd_data  <= stb_rd;
                  cnt      <= cnt + LEN_W'(1);
               end else if (!pend && !rd_valid && cnt == len_q) state <= S_DONE;
            end
            S_STAT_CMD: if (stb_done) state <= S_STAT_RD;
            S_STAT_RD: if (stb_done) begin
               status_fail <= stb_rd[0];
               state       <= S_DONE;
            end
            default: begin done <= 1'b1; state <= S_IDLE; end
         endcase
      end
   end

   a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
   a_r12_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT) && !rb_s |=> (state == S_WAIT));
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nsq_pkg::*;
#(
   parameter int ROW_W   = 17,
   parameter int COL_W   = 10,
   parameter int LEN_W   = 10,
   parameter int T_SETUP = 2,
   parameter int T_WL    = 3,
   parameter int T_WH    = 2,
   parameter int T_RL    = 3,
   parameter int T_RH    = 2,
   parameter int T_WB    = 4,
   parameter int RB_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_op,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic             done,
   output logic             status_fail,
   output logic             nf_ce_n,
   output logic             nf_cle,
   output logic             nf_ale,
   output logic             nf_we_n,
   output logic             nf_re_n,
   output logic [7:0]       nf_io_out,
   output logic             nf_io_oe,
   input  logic [7:0]       nf_io_in,
   input  logic             nf_rb
);
   if (ROW_W < 1 || ROW_W > 24) begin : g_bad_row
      $error("ROW_W must be 1..24");
   end
   if (COL_W != 10) begin : g_bad_col
      $error("COL_W must be 10 for the pointer scheme");
   end
   if (T_SETUP < 1 || T_WL < 1 || T_WH < 1 || T_RL < 1 || T_RH < 1 || T_WB < 1) begin : g_bad_t
      $error("all timing counts must be at least 1");
   end
   if (RB_SYNC < 0) begin : g_bad_sync
      $error("RB_SYNC must not be negative");
   end

   logic       rb_s;
   logic       stb_start, stb_done;
   nsq_kind_e  stb_kind;
   logic [7:0] stb_byte, stb_rd;

   if (RB_SYNC == 0) begin : g_rb_direct
      assign rb_s = nf_rb;
   end else begin : g_rb_sync
      logic [RB_SYNC-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= (sh << 1) | RB_SYNC'(nf_rb);
      end
      assign rb_s = sh[RB_SYNC-1];
   end

   nsq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .T_WB(T_WB)) u_ctrl (
      .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_row, .req_col, .req_len,
      .wr_data, .wr_valid, .wr_ready, .rd_data, .rd_valid, .rd_ready, .done,
      .status_fail, .ce_n(nf_ce_n), .rb_s, .stb_start, .stb_kind, .stb_byte,
      .stb_done, .stb_rd
   );

   nsq_strobe #(.T_SETUP(T_SETUP), .T_WL(T_WL), .T_WH(T_WH), .T_RL(T_RL), .T_RH(T_RH)) u_stb (
      .clk, .rst_n, .start(stb_start), .kind(stb_kind), .byte_in(stb_byte),
      .io_in(nf_io_in), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
      .io_out(nf_io_out), .io_oe(nf_io_oe), .rd_byte(stb_rd), .done(stb_done)
   );

   a_r1_ce_with_we: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_we_n |-> !nf_ce_n);
   a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_io_oe);
   a_r11_ce_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> nf_we_n && nf_re_n);

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
   localparam int T_SETUP = 2, T_WL = 3, T_WH = 2, T_RL = 3, T_RH = 2, T_WB = 4;
   localparam int BUSY = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        req_valid = 1'b0, req_ready;
   logic [2:0]  req_op = '0;
   logic [16:0] req_row = '0;
   logic [9:0]  req_col = '0, req_len = '0;
   logic [7:0]  wr_data = '0, rd_data, nf_io_out, nf_io_in;
   logic        wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b1, done, status_fail;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, nf_rb;

   nand_cmd_seq #(.T_SETUP(T_SETUP), .T_WL(T_WL), .T_WH(T_WH), .T_RL(T_RL),
                  .T_RH(T_RH), .T_WB(T_WB)) u_dut (.*);

   int n_tests = 0, n_fail = 0, cyc = 0, done_seen = 0;
   logic [9:0] exp_bus[$];
   logic [7:0] exp_rd[$];
   logic [7:0] wr_q[$];
   logic [7:0] stat_val = 8'h00;
   logic       exp_fail = 1'b0, chk_fail = 1'b0, rd_bp = 1'b0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] sbyte(int k);
      return 8'(k * 37 + 11);
   endfunction

   // flash stub
   logic [7:0] last_cmd = 8'hFF;
   int idx = 0, acnt = 0, busy = 0;
   logic s_we_p = 1'b1, s_re_p = 1'b1;
   assign nf_rb    = (busy == 0);
   assign nf_io_in = (last_cmd == 8'h70) ? stat_val : sbyte(idx);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (busy > 0) busy <= busy - 1;
      if (nf_we_n && !s_we_p && !nf_ce_n) begin
         if (nf_cle) begin
            last_cmd <= nf_io_out; idx <= 0; acnt <= 0;
            if (nf_io_out == 8'h10 || nf_io_out == 8'hD0 || nf_io_out == 8'hFF) busy <= BUSY;
         end else if (nf_ale) begin
            acnt <= acnt + 1;
            if (acnt == 3 && (last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50))
               busy <= BUSY;
         end
      end
      if (nf_re_n && !s_re_p) idx <= idx + 1;
      s_we_p <= nf_we_n;
      s_re_p <= nf_re_n;
      rd_ready <= rd_bp ? (cyc % 4 == 3) : 1'b1;
   end

   // write stream feeder with gaps
   always @(posedge clk) begin
      if (wr_valid && wr_ready) void'(wr_q.pop_front());
      if (wr_q.size() > 0 && (cyc % 3 != 1)) begin
         wr_valid <= 1'b1; wr_data <= wr_q[0];
      end else wr_valid <= 1'b0;
   end

   // monitor / scoreboard
   logic m_we_p = 1'b1, m_re_p = 1'b1;
   int wl = 0, rl = 0;
   always @(negedge clk) if (rst_n) begin
      if (!nf_we_n && m_we_p) begin
         check(!nf_ce_n, "R1", "ce_n at write strobe", nf_ce_n, 0);
         check(nf_rb, "R12", "write strobe while busy", nf_rb, 1);
      end
      if (!nf_re_n && m_re_p) begin
         check(nf_rb, "R12", "read strobe while busy", nf_rb, 1);
         check(!nf_io_oe, "R8", "bus driven during read", nf_io_oe, 0);
      end
      if (!nf_we_n) wl++;
      if (!nf_re_n) rl++;
      if (nf_we_n && !m_we_p) begin
         logic [1:0] k;
         k = (nf_cle && !nf_ale) ? 2'd1 : (nf_ale && !nf_cle) ? 2'd2 :
             (!nf_cle && !nf_ale) ? 2'd3 : 2'd0;
         check(wl == T_WL, "R7", "write low width", wl, T_WL);
         wl = 0;
         if (exp_bus.size() == 0)
            check(0, "R2", "unexpected bus byte", {k, nf_io_out}, 0);
         else begin
            logic [9:0] e;
            e = exp_bus.pop_front();
            check({k, nf_io_out} == e, (e[9:8] == 2'd1) ? "R2" : (e[9:8] == 2'd2) ? "R3" : "R4",
                  "bus item {kind,byte}", {k, nf_io_out}, e);
         end
      end
      if (nf_re_n && !m_re_p) begin
         check(rl == T_RL, "R7", "read low width", rl, T_RL);
         rl = 0;
      end
      if (rd_valid && rd_ready) begin
         if (exp_rd.size() == 0) check(0, "R8", "unexpected read byte", rd_data, 0);
         else begin
            logic [7:0] e;
            e = exp_rd.pop_front();
            check(rd_data == e, "R8", "read data", rd_data, e);
         end
      end
      if (done) begin
         done_seen++;
         if (chk_fail) check(status_fail == exp_fail, "R6", "status_fail", status_fail, exp_fail);
      end
      m_we_p = nf_we_n;
      m_re_p = nf_re_n;
   end

   always @(posedge clk) if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic push(logic [1:0] k, logic [7:0] b);
      exp_bus.push_back({k, b});
   endtask

   function automatic logic [7:0] ptr(logic [9:0] c);
      return (c >= 512) ? 8'h50 : (c >= 256) ? 8'h01 : 8'h00;
   endfunction

   task automatic push_row(logic [16:0] r);
      push(2, r[7:0]); push(2, r[15:8]); push(2, {7'b0, r[16]});
   endtask

   task automatic issue(logic [2:0] op, logic [16:0] r, logic [9:0] c, logic [9:0] n, string req);
      int d0;
      int t0;
      d0 = done_seen;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_row = r; req_col = c; req_len = n;
      @(negedge clk);
      req_valid = 1'b0;
      t0 = cyc;
      while (done_seen == d0) @(negedge clk);
      check(exp_bus.size() == 0, req, "bus items left", exp_bus.size(), 0);
      check(exp_rd.size() == 0, req, "read bytes left", exp_rd.size(), 0);
      check(req_ready && nf_ce_n, "R11", "idle after done", {req_ready, nf_ce_n}, 3);
      check(cyc - t0 > 0, req, "operation took cycles", cyc - t0, 1);
   endtask

   task automatic do_read(logic [16:0] r, logic [9:0] c, int n);
      push(1, ptr(c)); push(2, c[7:0]); push_row(r);
      for (int k = 0; k < n; k++) exp_rd.push_back(sbyte(k));
      chk_fail = 1'b0;
      issue(3'd0, r, c, 10'(n), "R3");
   endtask

   task automatic do_prog(logic [16:0] r, logic [9:0] c, int n, logic [7:0] st);
      push(1, ptr(c)); push(1, 8'h80); push(2, c[7:0]); push_row(r);
      for (int k = 0; k < n; k++) begin
         push(3, 8'(k * 13 + 5)); wr_q.push_back(8'(k * 13 + 5));
      end
      push(1, 8'h10); push(1, 8'h70);
      stat_val = st; exp_fail = st[0]; chk_fail = 1'b1;
      issue(3'd1, r, c, 10'(n), "R4");
   endtask

   task automatic do_erase(logic [16:0] r, logic [7:0] st);
      push(1, 8'h60); push_row(r); push(1, 8'hD0); push(1, 8'h70);
      stat_val = st; exp_fail = st[0]; chk_fail = 1'b1;
      issue(3'd2, r, 10'd0, 10'd0, "R5");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
      check({nf_ce_n, nf_we_n, nf_re_n} == 3'b111, "R11", "strobes in reset",
            {nf_ce_n, nf_we_n, nf_re_n}, 7);
      check({nf_cle, nf_ale, rd_valid, done} == 4'b0, "R2", "qualifiers in reset",
            {nf_cle, nf_ale, rd_valid, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9: reset op
      push(1, 8'hFF); chk_fail = 1'b0;
      issue(3'd3, '0, '0, '0, "R9");
      // R10: status op, pass then fail
      push(1, 8'h70); stat_val = 8'hC0; exp_fail = 1'b0; chk_fail = 1'b1;
      issue(3'd4, '0, '0, '0, "R10");
      push(1, 8'h70); stat_val = 8'h41; exp_fail = 1'b1;
      issue(3'd4, '0, '0, '0, "R10");

      // R3/R8: reads in three column regions
      do_read(17'h12345, 10'd5, 4);
      rd_bp = 1'b1;
      do_read(17'h0ABCD, 10'd300, 3);
      do_read(17'h1FFFF, 10'd515, 2);
      rd_bp = 1'b0;

      // R4/R6: program pass and fail
      do_prog(17'h1F00F, 10'd0, 5, 8'hE0);
      do_prog(17'h00421, 10'd260, 3, 8'hE1);
      do_prog(17'h10001, 10'd520, 2, 8'h00);

      // R5/R6: erase fail and pass
      do_erase(17'h10020, 8'h01);
      do_erase(17'h0FFE0, 8'h80);

      // R8: single byte read under backpressure
      rd_bp = 1'b1;
      do_read(17'h00007, 10'd511, 1);
      rd_bp = 1'b0;

      repeat (5) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule